// File: doc/BRIEF.md
# Clock Control and Fault-Reset Register Slice

This block is the software-visible control slice of a clock-generation unit. It keeps the settings that steer the clock generator: a clock-source select, a low-power mode field and a PLL pre-divider. It also keeps two fault policies, one for processor checkstop and one for loss of PLL lock. A separate change-of-lock register holds an interrupt level, an enable and a write-one-to-clear status bit. Writes and reads use a simple synchronous bus: a write takes effect at the clock edge where it is presented, and read data is combinational.

The block watches three inputs. The processor checkstop and the PLL lock indication are asynchronous and pass through a synchronizer first. The debug-enable strap is captured once after each hard reset. Two state machines act on the synchronized inputs.

The lock tracker has three states: UNLOCKED, LOCKED and DRAIN. Its transitions are:
- UNLOCKED to LOCKED when lock is seen.
- LOCKED to UNLOCKED when lock is lost.
- UNLOCKED or LOCKED to DRAIN on a pre-divider change while lock is still seen.
- DRAIN to UNLOCKED once the PLL drops lock.

The checkstop sequencer has four states: ARMED, RST (reset pulse), DBG (debug pulse) and WAIT (checkstop still high, or ignored). Its transitions are:
- ARMED to DBG on a checkstop when debug was strapped.
- ARMED to RST on a checkstop when the reset enable is set.
- ARMED to WAIT on a checkstop when neither applies.
- RST, DBG or WAIT to WAIT while checkstop stays high.
- RST, DBG or WAIT to ARMED once checkstop falls.

Top module: `clkctl_regs`

## Requirements
- R1: After hard reset every output is 0, and every register reads 0.
- R2: A write to address 0 loads the pre-divider (bits 4:0), the low-power mode (bits 6:5), the clock-source select (bit 7, 0 = high-frequency divider, 1 = low-frequency divider) and the loss-of-lock reset enable (bit 9). The new values drive the outputs and read back from the next cycle. Readback also shows the lock state in bit 10 and the captured debug strap in bit 11.
- R3: Address 2 holds two lock bits. Bit 0 protects the mode field and the clock-source select; bit 1 protects the pre-divider. Writing 1 sets a lock bit and writing 0 has no effect, so a lock bit clears only on hard reset. While bit 0 is set, writes leave the mode field and the clock-source select unchanged.
- R4: While lock bit 1 is set, writes leave the pre-divider unchanged.
- R5: An accepted write that changes the pre-divider value drops `pll_locked_o` from the next cycle. Lock is reported again only after the PLL input has gone low and then high again.
- R6: The checkstop reset enable (address 0, bit 8) takes only the first write after a hard reset or after a soft reset. Later writes leave it unchanged. A soft reset clears it to 0.
- R7: If the debug strap was 1 when captured, a checkstop rising edge gives a one-cycle `dbg_req_o` pulse and never a `hreset_req_o` pulse.
- R8: If the debug strap was 0 and the checkstop enable is 1, a checkstop rising edge gives a one-cycle `hreset_req_o` pulse. If the enable is 0, the checkstop is ignored.
- R9: Leaving the locked state gives a one-cycle `hreset_req_o` pulse when the loss-of-lock enable is 1, and no pulse when it is 0.
- R10: Address 1 holds the level (bits 3:0), the status (bit 8) and the enable (bit 9). The status is set by every change of the reported lock state. `irq_level_o` equals the level while status and enable are both 1, and is 0 otherwise.
- R11: Writing 1 to status bit 8 clears it, and writing 0 leaves it unchanged. A lock change in the same cycle as a clearing write leaves the status set.
- R12: Address 3 and all reserved bits read as 0. Read data is 0 unless a read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst_n | input | 1 | Synchronous active-low soft reset |
| dbg_cfg_i | input | 1 | Debug-enable strap, captured after hard reset |
| checkstop_i | input | 1 | Processor checkstop indication (asynchronous) |
| pll_lock_i | input | 1 | PLL lock indication (asynchronous) |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| clk_sel_o | output | 1 | Clock-source select |
| lpm_o | output | 2 | Low-power mode |
| prediv_o | output | 5 | PLL pre-divider |
| pll_locked_o | output | 1 | Reported lock state |
| hreset_req_o | output | 1 | Hard reset request pulse |
| dbg_req_o | output | 1 | Debug entry request pulse |
| irq_level_o | output | 4 | Change-of-lock interrupt level |

## Verification
Register writes show on the outputs and in readback one cycle after the write cycle, and read data is checked in the same cycle as the read. A change on the checkstop or lock input reaches the state machines after the two synchronizer stages, so the request pulses, the lock output and the status bit change at the third edge after the input changes. The interrupt level follows the status on the same edge. The bench model uses the same stage counts, is compared on every falling edge, and counts pulses over windows wide enough to cover the latency. The status-set priority is tested by placing the clearing write exactly on that third edge.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int DIV_W  = 5;
    localparam int LPM_W  = 2;
    localparam int LVL_W  = 4;

    // control register layout
    localparam int DIV_LSB    = 0;
    localparam int LPM_LSB    = DIV_LSB + DIV_W;
    localparam int CSEL_BIT   = LPM_LSB + LPM_W;
    localparam int CHKEN_BIT  = CSEL_BIT + 1;
    localparam int LOLEN_BIT  = CHKEN_BIT + 1;
    localparam int LOCKED_BIT = LOLEN_BIT + 1;
    localparam int DBG_BIT    = LOCKED_BIT + 1;

    // change-of-lock register layout
    localparam int LVL_LSB = 0;
    localparam int STS_BIT = 8;
    localparam int EN_BIT  = 9;

    // lock register layout
    localparam int LK_LPM_BIT = 0;
    localparam int LK_DIV_BIT = 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_COLI = 2'd1;
    localparam logic [ADDR_W-1:0] A_LOCK = 2'd2;

    typedef enum logic [1:0] {
        L_UNLOCKED = 2'd0,
        L_LOCKED   = 2'd1,
        L_DRAIN    = 2'd2
    } lock_st_e;

    typedef enum logic [1:0] {
        C_ARMED = 2'd0,
        C_RST   = 2'd1,
        C_DBG   = 2'd2,
        C_WAIT  = 2'd3
    } chk_st_e;
endpackage

// File: rtl/clkctl_sync.sv
module clkctl_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clkctl_lock_fsm.sv
module clkctl_lock_fsm
    import clkctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s_i,
    input  logic div_change_i,
    input  logic lol_en_i,
    output logic locked_o,
    output logic lock_evt_o,
    output logic lol_pulse_o
);
    lock_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= L_UNLOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L_UNLOCKED: begin
                if (div_change_i)  state_d = lock_s_i ? L_DRAIN : L_UNLOCKED;
                else if (lock_s_i) state_d = L_LOCKED;
            end
            L_LOCKED: begin
                if (div_change_i)   state_d = L_DRAIN;
                else if (!lock_s_i) state_d = L_UNLOCKED;
            end
            L_DRAIN: begin
                if (!lock_s_i) state_d = L_UNLOCKED;
            end
            default: state_d = L_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lol_pulse_o <= 1'b0;
        else        lol_pulse_o <= lol_en_i && (state_q == L_LOCKED) && (state_d != L_LOCKED);
    end

    always_comb begin
        locked_o   = (state_q == L_LOCKED);
        lock_evt_o = (state_q == L_LOCKED) != (state_d == L_LOCKED);
    end

    // R5: a pre-divider change removes the reported lock on the next cycle
    p_div_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_change_i |=> !locked_o);

    // R9: leaving lock with the enable set raises the reset pulse
    p_lol_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked_o) && !locked_o && $past(lol_en_i)) |-> lol_pulse_o);
endmodule

// File: rtl/clkctl_chk_fsm.sv
module clkctl_chk_fsm
    import clkctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chk_s_i,
    input  logic dbg_mode_i,
    input  logic chk_en_i,
    output logic rst_pulse_o,
    output logic dbg_pulse_o
);
    chk_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= C_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            C_ARMED: begin
                if (chk_s_i) begin
                    if (dbg_mode_i)    state_d = C_DBG;
                    else if (chk_en_i) state_d = C_RST;
                    else               state_d = C_WAIT;
                end
            end
            C_RST, C_DBG, C_WAIT: begin
                state_d = chk_s_i ? C_WAIT : C_ARMED;
            end
            default: state_d = C_ARMED;
        endcase
    end

    always_comb begin
        rst_pulse_o = (state_q == C_RST);
        dbg_pulse_o = (state_q == C_DBG);
    end

    // R7: with debug strapped, checkstop never requests a reset
    p_dbg_no_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode_i |-> !rst_pulse_o);

    // R8: the checkstop reset request lasts a single cycle
    p_chk_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o |=> !rst_pulse_o);

    // R7: the debug request lasts a single cycle
    p_dbg_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_pulse_o |=> !dbg_pulse_o);
endmodule

// File: rtl/clkctl_coli.sv
module clkctl_coli
    import clkctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              evt_i,
    output logic [DATA_W-1:0] rd_o,
    output logic [LVL_W-1:0]  irq_o
);
    logic [LVL_W-1:0] lvl_q;
    logic             en_q;
    logic             sts_q;
    logic             clr;

    assign clr = wr_i && wdata_i[STS_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            en_q  <= 1'b0;
            sts_q <= 1'b0;
        end else begin
            if (wr_i) begin
                lvl_q <= wdata_i[LVL_LSB +: LVL_W];
                en_q  <= wdata_i[EN_BIT];
            end
            sts_q <= evt_i || (sts_q && !clr);
        end
    end

    always_comb begin
        rd_o                      = '0;
        rd_o[LVL_LSB +: LVL_W]    = lvl_q;
        rd_o[STS_BIT]             = sts_q;
        rd_o[EN_BIT]              = en_q;
        irq_o                     = (sts_q && en_q) ? lvl_q : '0;
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[DATA_W-1:EN_BIT+1], wdata_i[STS_BIT-1:LVL_LSB+LVL_W]};

    // R11: a lock change sets the status even against a clearing write
    p_evt_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> sts_q);

    // R11: without a lock change, writing 0 to the status keeps it
    p_w0_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !clr) |=> sts_q);
endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_n,
    input  logic              dbg_cfg_i,
    input  logic              checkstop_i,
    input  logic              pll_lock_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              clk_sel_o,
    output logic [LPM_W-1:0]  lpm_o,
    output logic [DIV_W-1:0]  prediv_o,
    output logic              pll_locked_o,
    output logic              hreset_req_o,
    output logic              dbg_req_o,
    output logic [LVL_W-1:0]  irq_level_o
);
    logic chk_s, lock_s;
    logic wr_ctrl, wr_coli, wr_lock, rd_en;

    logic [DIV_W-1:0] div_q;
    logic [LPM_W-1:0] lpm_q;
    logic             csel_q;
    logic             chk_en_q, chk_wr_q;
    logic             lol_en_q;
    logic             lk_lpm_q, lk_div_q;
    logic             cap_q, dbg_q;
    logic             div_change;

    logic             locked, lock_evt, lol_pulse;
    logic             chk_rst, chk_dbg;
    logic [DATA_W-1:0] coli_rd;

    clkctl_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({checkstop_i, pll_lock_i}),
        .q     ({chk_s, lock_s})
    );

    always_comb begin
        wr_ctrl = bus_en_i && bus_we_i && (bus_addr_i == A_CTRL);
        wr_coli = bus_en_i && bus_we_i && (bus_addr_i == A_COLI);
        wr_lock = bus_en_i && bus_we_i && (bus_addr_i == A_LOCK);
        rd_en   = bus_en_i && !bus_we_i;
        div_change = wr_ctrl && !lk_div_q
                     && (bus_wdata_i[DIV_LSB +: DIV_W] != div_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            lpm_q    <= '0;
            csel_q   <= 1'b0;
            lol_en_q <= 1'b0;
            chk_en_q <= 1'b0;
            chk_wr_q <= 1'b0;
            lk_lpm_q <= 1'b0;
            lk_div_q <= 1'b0;
            cap_q    <= 1'b0;
            dbg_q    <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                if (!lk_lpm_q) begin
                    lpm_q  <= bus_wdata_i[LPM_LSB +: LPM_W];
                    csel_q <= bus_wdata_i[CSEL_BIT];
                end
                if (!lk_div_q) div_q <= bus_wdata_i[DIV_LSB +: DIV_W];
                lol_en_q <= bus_wdata_i[LOLEN_BIT];
            end
            if (!soft_rst_n) begin
                chk_en_q <= 1'b0;
                chk_wr_q <= 1'b0;
            end else if (wr_ctrl && !chk_wr_q) begin
                chk_en_q <= bus_wdata_i[CHKEN_BIT];
                chk_wr_q <= 1'b1;
            end
            if (wr_lock) begin
                lk_lpm_q <= lk_lpm_q | bus_wdata_i[LK_LPM_BIT];
                lk_div_q <= lk_div_q | bus_wdata_i[LK_DIV_BIT];
            end
            if (!cap_q) begin
                cap_q <= 1'b1;
                dbg_q <= dbg_cfg_i;
            end
        end
    end

    clkctl_lock_fsm u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .lock_s_i     (lock_s),
        .div_change_i (div_change),
        .lol_en_i     (lol_en_q),
        .locked_o     (locked),
        .lock_evt_o   (lock_evt),
        .lol_pulse_o  (lol_pulse)
    );

    clkctl_chk_fsm u_chk (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_s_i     (chk_s),
        .dbg_mode_i  (dbg_q),
        .chk_en_i    (chk_en_q),
        .rst_pulse_o (chk_rst),
        .dbg_pulse_o (chk_dbg)
    );

    clkctl_coli u_coli (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_coli),
        .wdata_i (bus_wdata_i),
        .evt_i   (lock_evt),
        .rd_o    (coli_rd),
        .irq_o   (irq_level_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (rd_en) begin
            unique case (bus_addr_i)
                A_CTRL: begin
                    bus_rdata_o[DIV_LSB +: DIV_W] = div_q;
                    bus_rdata_o[LPM_LSB +: LPM_W] = lpm_q;
                    bus_rdata_o[CSEL_BIT]         = csel_q;
                    bus_rdata_o[CHKEN_BIT]        = chk_en_q;
                    bus_rdata_o[LOLEN_BIT]        = lol_en_q;
                    bus_rdata_o[LOCKED_BIT]       = locked;
                    bus_rdata_o[DBG_BIT]          = dbg_q;
                end
                A_COLI: bus_rdata_o = coli_rd;
                A_LOCK: begin
                    bus_rdata_o[LK_LPM_BIT] = lk_lpm_q;
                    bus_rdata_o[LK_DIV_BIT] = lk_div_q;
                end
                default: bus_rdata_o = '0;
            endcase
        end
    end

    always_comb begin
        clk_sel_o    = csel_q;
        lpm_o        = lpm_q;
        prediv_o     = div_q;
        pll_locked_o = locked;
        hreset_req_o = chk_rst || lol_pulse;
        dbg_req_o    = chk_dbg;
    end

    // R3: mode and clock-source select are frozen under their lock
    p_lpm_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_lpm_q |=> ($stable(lpm_o) && $stable(clk_sel_o)));

    // R3: a lock bit never clears without hard reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_lpm_q && lk_div_q) |=> (lk_lpm_q && lk_div_q));

    // R4: pre-divider frozen under its lock
    p_div_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_div_q |=> $stable(prediv_o));

    // R6: once written, the checkstop enable holds until a soft reset
    p_chk_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_wr_q && soft_rst_n) |=> $stable(chk_en_q));

    // R12: no read strobe, no read data
    p_rd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (bus_rdata_o == '0));
endmodule

// File: tb/clkctl_regs_test.sv
`timescale 1ns/1ps
module clkctl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic        dbg_cfg_i = 1'b0;
    logic        checkstop_i = 1'b0;
    logic        pll_lock_i = 1'b0;
    logic        bus_en_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [1:0]  bus_addr_i = 2'd0;
    logic [15:0] bus_wdata_i = 16'd0;
    logic [15:0] bus_rdata_o;
    logic        clk_sel_o;
    logic [1:0]  lpm_o;
    logic [4:0]  prediv_o;
    logic        pll_locked_o;
    logic        hreset_req_o;
    logic        dbg_req_o;
    logic [3:0]  irq_level_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clkctl_regs uut (
        .clk(clk), .rst_n(rst_n), .soft_rst_n(soft_rst_n), .dbg_cfg_i(dbg_cfg_i),
        .checkstop_i(checkstop_i), .pll_lock_i(pll_lock_i),
        .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .clk_sel_o(clk_sel_o), .lpm_o(lpm_o), .prediv_o(prediv_o),
        .pll_locked_o(pll_locked_o), .hreset_req_o(hreset_req_o),
        .dbg_req_o(dbg_req_o), .irq_level_o(irq_level_o)
    );

    // behavioural reference model
    bit       m_ls1, m_ls2, m_cs1, m_cs2, m_cap, m_dbg;
    bit [4:0] m_div;
    bit [1:0] m_lpm, m_lk;
    bit       m_csel, m_chk_en, m_chk_wr, m_lol_en, m_lolp, m_en, m_sts;
    bit [3:0] m_lvl;
    int       m_lst, m_cst;   // lock: 0 unlocked 1 locked 2 drain; chk: 0 armed 1 rst 2 dbg 3 wait

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ls1 = 0; m_ls2 = 0; m_cs1 = 0; m_cs2 = 0; m_cap = 0; m_dbg = 0;
            m_div = 0; m_lpm = 0; m_lk = 0; m_csel = 0; m_chk_en = 0; m_chk_wr = 0;
            m_lol_en = 0; m_lolp = 0; m_en = 0; m_sts = 0; m_lvl = 0;
            m_lst = 0; m_cst = 0;
        end else begin
            bit w0, w1, w2, divchg, evt;
            int n_lst, n_cst;
            w0 = bus_en_i && bus_we_i && bus_addr_i == 2'd0;
            w1 = bus_en_i && bus_we_i && bus_addr_i == 2'd1;
            w2 = bus_en_i && bus_we_i && bus_addr_i == 2'd2;
            divchg = w0 && !m_lk[1] && (bus_wdata_i[4:0] != m_div);
            case (m_lst)
                0: n_lst = divchg ? (m_ls2 ? 2 : 0) : (m_ls2 ? 1 : 0);
                1: n_lst = divchg ? 2 : (m_ls2 ? 1 : 0);
                default: n_lst = m_ls2 ? 2 : 0;
            endcase
            evt = (m_lst == 1) != (n_lst == 1);
            m_lolp = (m_lst == 1) && (n_lst != 1) && m_lol_en;
            if (m_cst == 0) n_cst = m_cs2 ? (m_dbg ? 2 : (m_chk_en ? 1 : 3)) : 0;
            else            n_cst = m_cs2 ? 3 : 0;
            m_sts = evt || (m_sts && !(w1 && bus_wdata_i[8]));
            if (w1) begin m_lvl = bus_wdata_i[3:0]; m_en = bus_wdata_i[9]; end
            if (w0) begin
                if (!m_lk[0]) begin m_lpm = bus_wdata_i[6:5]; m_csel = bus_wdata_i[7]; end
                if (!m_lk[1]) m_div = bus_wdata_i[4:0];
                m_lol_en = bus_wdata_i[9];
            end
            if (!soft_rst_n) begin m_chk_en = 0; m_chk_wr = 0; end
            else if (w0 && !m_chk_wr) begin m_chk_en = bus_wdata_i[8]; m_chk_wr = 1; end
            if (w2) m_lk = m_lk | bus_wdata_i[1:0];
            if (!m_cap) begin m_cap = 1; m_dbg = dbg_cfg_i; end
            m_ls2 = m_ls1; m_ls1 = pll_lock_i;
            m_cs2 = m_cs1; m_cs1 = checkstop_i;
            m_lst = n_lst; m_cst = n_cst;
        end
    end

    function automatic logic [15:0] m_rdata();
        logic [15:0] r = '0;
        if (bus_en_i && !bus_we_i) begin
            case (bus_addr_i)
                2'd0: r = {4'b0, m_dbg, (m_lst == 1), m_lol_en, m_chk_en, m_csel, m_lpm, m_div};
                2'd1: r = {6'b0, m_en, m_sts, 4'b0, m_lvl};
                2'd2: r = {14'b0, m_lk};
                default: r = '0;
            endcase
        end
        return r;
    endfunction

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        check(16'(prediv_o), 16'(m_div), "R4 prediv");
        check(16'(lpm_o), 16'(m_lpm), "R3 lpm");
        check(16'(clk_sel_o), 16'(m_csel), "R2 clk_sel");
        check(16'(pll_locked_o), 16'(m_lst == 1), "R5 locked");
        check(16'(hreset_req_o), 16'((m_cst == 1) || m_lolp), "R9 hreset");
        check(16'(dbg_req_o), 16'(m_cst == 2), "R7 dbg_req");
        check(16'(irq_level_o), (m_sts && m_en) ? 16'(m_lvl) : 16'd0, "R10 irq");
        check(bus_rdata_o, m_rdata(), "R12 rdata");
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_en_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_en_i = 0; bus_we_i = 0; bus_wdata_i = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
        #3 d = bus_rdata_o;
        @(negedge clk);
        bus_en_i = 0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_count(input int n, output int nr, output int nd);
        nr = 0; nd = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #3;
            nr += hreset_req_o; nd += dbg_req_o;
        end
    endtask

    task automatic scenario();
        logic [15:0] v;
        int nr, nd;
        cycles(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        #3;
        check(16'(hreset_req_o | dbg_req_o | pll_locked_o | clk_sel_o), 16'd0, "R1 outputs");
        check(16'(irq_level_o), 16'd0, "R1 irq");
        rd(2'd0, v); check(v, 16'h0000, "R1 ctrl read");
        rd(2'd1, v); check(v, 16'h0000, "R1 coli read");
        // R2 field load
        wr(2'd0, 16'h03C5);
        rd(2'd0, v); check(v, 16'h03C5, "R2 ctrl readback");
        check(16'(clk_sel_o), 16'd1, "R2 clk_sel low-freq");
        // R6 second write ignored for checkstop enable
        wr(2'd0, 16'h02C5);
        rd(2'd0, v); check(v & 16'h0100, 16'h0100, "R6 write-once");
        // R10 lock gained sets status
        pll_lock_i = 1; cycles(4);
        check(16'(pll_locked_o), 16'd1, "R10 locked");
        rd(2'd1, v); check(v, 16'h0100, "R10 status set");
        wr(2'd1, 16'h0209); #3;
        check(16'(irq_level_o), 16'd9, "R11 write 0 keeps status");
        wr(2'd1, 16'h0309); #3;
        check(16'(irq_level_o), 16'd0, "R11 write 1 clears");
        // R8 checkstop reset
        checkstop_i = 1; pulse_count(6, nr, nd);
        check(16'(nr), 16'd1, "R8 one reset pulse"); check(16'(nd), 16'd0, "R8 no debug");
        checkstop_i = 0; cycles(4);
        // R5 / R9 pre-divider change
        wr(2'd0, 16'h03C6); #3;
        check(16'(pll_locked_o), 16'd0, "R5 unlock on divider change");
        check(16'(hreset_req_o), 16'd1, "R9 loss-of-lock reset");
        cycles(5);
        check(16'(pll_locked_o), 16'd0, "R5 waits for lock drop");
        pll_lock_i = 0; cycles(4); pll_lock_i = 1; cycles(4);
        check(16'(pll_locked_o), 16'd1, "R5 relocked");
        // R6 soft reset re-arms
        soft_rst_n = 0; @(negedge clk); soft_rst_n = 1;
        rd(2'd0, v); check(v & 16'h0100, 16'h0000, "R6 soft reset clears");
        wr(2'd0, 16'h02C6); wr(2'd0, 16'h03C6);
        rd(2'd0, v); check(v & 16'h0100, 16'h0000, "R6 later write ignored");
        checkstop_i = 1; pulse_count(6, nr, nd); checkstop_i = 0;
        check(16'(nr), 16'd0, "R8 disabled checkstop ignored");
        cycles(3);
        // R9 disabled
        wr(2'd0, 16'h00C6);
        pll_lock_i = 0; pulse_count(6, nr, nd);
        check(16'(nr), 16'd0, "R9 no reset when disabled");
        rd(2'd1, v); check(v & 16'h0100, 16'h0100, "R10 loss sets status");
        pll_lock_i = 1; cycles(4);
        // R3 / R4 locks
        wr(2'd2, 16'h0001); wr(2'd0, 16'h0026);
        check(16'(lpm_o), 16'd2, "R3 lpm locked");
        check(16'(clk_sel_o), 16'd1, "R3 clk_sel locked");
        wr(2'd2, 16'h0002); wr(2'd0, 16'h0007);
        check(16'(prediv_o), 16'd6, "R4 divider locked");
        wr(2'd2, 16'h0000);
        rd(2'd2, v); check(v, 16'h0003, "R3 lock bits sticky");
        // R11 set beats clear
        wr(2'd1, 16'h0100);
        pll_lock_i = 0; @(negedge clk); @(negedge clk);
        wr(2'd1, 16'h0100);
        rd(2'd1, v); check(v & 16'h0100, 16'h0100, "R11 set priority");
        // R12 reserved address
        rd(2'd3, v); check(v, 16'h0000, "R12 reserved reads 0");
        // R7 debug strapped
        rst_n = 0; dbg_cfg_i = 1; cycles(3); rst_n = 1; @(negedge clk);
        wr(2'd0, 16'h0100);
        rd(2'd0, v); check(v & 16'h0800, 16'h0800, "R7 strap captured");
        checkstop_i = 1; pulse_count(6, nr, nd); checkstop_i = 0;
        check(16'(nd), 16'd1, "R7 debug pulse"); check(16'(nr), 16'd0, "R7 no reset");
        cycles(4);
    endtask

    initial begin
        fork
            scenario();
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule